// File: doc/BRIEF.md
# Embedded Register Row Parser

This block watches the receive side of a 12-bit parallel pixel bus and picks out rows that carry a dump of register settings instead of image pixels. The first word of a row decides what it is: a fixed tag word starts a register row, and any other word makes the block ignore that row. In a register row, each 8-bit payload byte sits in the upper bits of a word and its lower pad bits are zero. Every payload byte follows a fixed marker byte. The row opens with a header that gives one 16-bit start address. After the header come 16-bit register values, each sent as a high byte and then a low byte.

For each value it receives in full, the block gives out a one-clock strobe with the value and its address. No address is sent with the values, so the block rebuilds each one. The first value belongs to the header address, and each later value is two above the one before it. A malformed row raises a one-clock error flag, and the block then stays silent until the row ends. A row that is cut short in the middle of a field is also flagged. A downstream register shadow or a debug monitor can take the stream of address/value pairs.

Top module: `emb_row_parser`

## Requirements
- R1: A row is parsed only when its first accepted word equals 0x0A0. Any other first word makes the block produce no pair and no error until line-valid goes low.
- R2: Each payload byte is bits [11:4] of its word.
- R3: After the tag, the header is marker 0xAA, then the address high byte, then marker 0xA5, then the address low byte.
- R4: Each value is marker 0x5A, high byte, marker 0x5A, low byte, and is output as {high, low}. For example, words 0x120 then 0x340 give 0x1234.
- R5: The first value's address is the header address. Each later value in the row has an address 2 above the previous one, wrapping modulo 2^16 (0xFFFE is followed by 0x0000).
- R6: If a marker word's payload differs from the expected marker, err_o is high for one cycle, and the rest of the row gives no pair and no further error.
- R7: If any word after the tag has non-zero bits [3:0], the same error and silence as R6 apply.
- R8: When line_vld_i is low, the parser returns to idle. If the row ended inside the header or inside a value, err_o pulses once. A row that ends right after the header or right after a complete value ends without error.
- R9: pair_vld_o is high for exactly one clock per value. That clock is the cycle after the edge that takes the low byte, and pair_addr_o and pair_val_o are valid in that cycle. err_o also comes one cycle after the edge that detects the fault. After reset both are low.
- R10: A word is taken only on an edge where pix_vld_i and line_vld_i are both high. Words at other times have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_vld_i | input | 1 | Pixel word valid |
| line_vld_i | input | 1 | High for the duration of a row |
| pix_data_i | input | 12 | Pixel word |
| pair_vld_o | output | 1 | One-clock strobe for a decoded pair |
| pair_addr_o | output | 16 | Register address of the pair |
| pair_val_o | output | 16 | Register value of the pair |
| err_o | output | 1 | One-clock flag for a malformed or truncated row |

## Verification
The assertions assume that line-valid drops for at least one cycle between rows. They also assume that each complete value takes at least four accepted words, so two pair strobes can never fall on neighbouring cycles. The stimulus only drops line-valid between rows and drives every field as a whole word. It places idle cycles with junk data where pixel-valid is low, and it feeds junk words while line-valid is low. This exercises the R10 gating without breaking those assumptions.

// File: rtl/erp_pkg.sv
package erp_pkg;

  localparam int ERP_BYTE_W = 8;
  localparam logic [ERP_BYTE_W-1:0] MK_HDR_A = 8'hAA;
  localparam logic [ERP_BYTE_W-1:0] MK_HDR_B = 8'hA5;
  localparam logic [ERP_BYTE_W-1:0] MK_VAL   = 8'h5A;

  typedef enum logic [3:0] {
    ST_WAIT, ST_SKIP,
    ST_HMK1, ST_AHI, ST_HMK2, ST_ALO,
    ST_VMK1, ST_VHI, ST_VMK2, ST_VLO
  } erp_state_e;

  function automatic erp_state_e next_field(input erp_state_e s);
    case (s)
      ST_HMK1: return ST_AHI;
      ST_AHI:  return ST_HMK2;
      ST_HMK2: return ST_ALO;
      ST_ALO:  return ST_VMK1;
      ST_VMK1: return ST_VHI;
      ST_VHI:  return ST_VMK2;
      ST_VMK2: return ST_VLO;
      ST_VLO:  return ST_VMK1;
      default: return ST_SKIP;
    endcase
  endfunction

  function automatic logic is_marker(input erp_state_e s);
    return (s == ST_HMK1) || (s == ST_HMK2) || (s == ST_VMK1) || (s == ST_VMK2);
  endfunction

  function automatic logic [ERP_BYTE_W-1:0] marker_for(input erp_state_e s);
    case (s)
      ST_HMK1: return MK_HDR_A;
      ST_HMK2: return MK_HDR_B;
      default: return MK_VAL;
    endcase
  endfunction

  function automatic logic in_parse(input erp_state_e s);
    return (s != ST_WAIT) && (s != ST_SKIP);
  endfunction

  function automatic logic is_partial(input erp_state_e s);
    return in_parse(s) && (s != ST_VMK1);
  endfunction

endpackage

// File: rtl/erp_word_check.sv
module erp_word_check
  import erp_pkg::*;
#(
  parameter int PIX_W = 12,
  parameter int BYTE_W = ERP_BYTE_W,
  parameter logic [PIX_W-1:0] TAG_WORD = 12'h0A0
) (
  input  logic [PIX_W-1:0]  word_i,
  input  erp_state_e        state_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              pad_ok_o,
  output logic              tag_hit_o,
  output logic              marker_ok_o
);
  localparam int PAD_W = PIX_W - BYTE_W;

  function automatic logic [BYTE_W-1:0] payload_of(input logic [PIX_W-1:0] w);
    return w[PIX_W-1 -: BYTE_W];
  endfunction

  assign byte_o      = payload_of(word_i);
  assign tag_hit_o   = (word_i == TAG_WORD);
  assign marker_ok_o = (payload_of(word_i) == marker_for(state_i));

  generate
    if (PAD_W > 0) begin : g_pad
      assign pad_ok_o = (word_i[PAD_W-1:0] == '0);
    end else begin : g_nopad
      assign pad_ok_o = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/erp_addr_gen.sv
module erp_addr_gen #(
  parameter int ADDR_W = 16,
  parameter int ADDR_STEP = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_hi_i,
  input  logic                load_lo_i,
  input  logic                step_i,
  input  logic [ADDR_W/2-1:0] byte_i,
  output logic [ADDR_W-1:0]   addr_o
);
  localparam int HALF_W = ADDR_W / 2;

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(ADDR_STEP);
  endfunction

  logic [HALF_W-1:0] hi_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      addr_q <= '0;
    end else begin
      if (load_hi_i) hi_q <= byte_i;
      if (load_lo_i) addr_q <= {hi_q, byte_i};
      else if (step_i) addr_q <= step_addr(addr_q);
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/emb_row_parser.sv
module emb_row_parser
  import erp_pkg::*;
#(
  parameter int PIX_W = 12,
  parameter int ADDR_W = 16,
  parameter int ADDR_STEP = 2,
  parameter logic [PIX_W-1:0] TAG_WORD = 12'h0A0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_vld_i,
  input  logic              line_vld_i,
  input  logic [PIX_W-1:0]  pix_data_i,
  output logic              pair_vld_o,
  output logic [ADDR_W-1:0] pair_addr_o,
  output logic [ADDR_W-1:0] pair_val_o,
  output logic              err_o
);
  localparam int BYTE_W = ADDR_W / 2;

  function automatic logic [ADDR_W-1:0] join_bytes(input logic [BYTE_W-1:0] hi,
                                                   input logic [BYTE_W-1:0] lo);
    return {hi, lo};
  endfunction

  erp_state_e state_q, state_d;
  logic [BYTE_W-1:0] byte_w, val_hi_q;
  logic [ADDR_W-1:0] cur_addr;
  logic pad_ok, tag_hit, marker_ok;

  // named internal events
  logic ev_take, ev_bad, ev_trunc, ev_emit, ev_load_hi, ev_load_lo, ev_val_hi;

  erp_word_check #(.PIX_W(PIX_W), .BYTE_W(BYTE_W), .TAG_WORD(TAG_WORD)) u_check (
    .word_i(pix_data_i), .state_i(state_q), .byte_o(byte_w),
    .pad_ok_o(pad_ok), .tag_hit_o(tag_hit), .marker_ok_o(marker_ok)
  );

  assign ev_take    = pix_vld_i && line_vld_i;
  assign ev_bad     = ev_take && in_parse(state_q) &&
                      (!pad_ok || (is_marker(state_q) && !marker_ok));
  assign ev_trunc   = !line_vld_i && is_partial(state_q);
  assign ev_emit    = ev_take && (state_q == ST_VLO) && !ev_bad;
  assign ev_load_hi = ev_take && (state_q == ST_AHI) && !ev_bad;
  assign ev_load_lo = ev_take && (state_q == ST_ALO) && !ev_bad;
  assign ev_val_hi  = ev_take && (state_q == ST_VHI) && !ev_bad;

  erp_addr_gen #(.ADDR_W(ADDR_W), .ADDR_STEP(ADDR_STEP)) u_addr (
    .clk(clk), .rst_n(rst_n), .load_hi_i(ev_load_hi), .load_lo_i(ev_load_lo),
    .step_i(ev_emit), .byte_i(byte_w), .addr_o(cur_addr)
  );

  always_comb begin
    state_d = state_q;
    if (!line_vld_i) begin
      state_d = ST_WAIT;
    end else if (ev_take) begin
      case (state_q)
        ST_WAIT: state_d = tag_hit ? ST_HMK1 : ST_SKIP;
        ST_SKIP: state_d = ST_SKIP;
        default: state_d = ev_bad ? ST_SKIP : next_field(state_q);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_WAIT;
      val_hi_q    <= '0;
      pair_vld_o  <= 1'b0;
      pair_addr_o <= '0;
      pair_val_o  <= '0;
      err_o       <= 1'b0;
    end else begin
      state_q    <= state_d;
      pair_vld_o <= ev_emit;
      err_o      <= ev_bad || ev_trunc;
      if (ev_val_hi) val_hi_q <= byte_w;
      if (ev_emit) begin
        pair_addr_o <= cur_addr;
        pair_val_o  <= join_bytes(val_hi_q, byte_w);
      end
    end
  end

  // R9: one strobe per value, never back to back
  p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pair_vld_o |=> !pair_vld_o);
  // R6: a faulty row never yields a pair in the same cycle as its error
  p_err_no_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !pair_vld_o);
  // R7: a padded word with stray low bits is reported next cycle
  p_pad_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_take && in_parse(state_q) && !pad_ok) |=> err_o);
  // R8: line-valid low returns to idle
  p_line_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !line_vld_i |=> (state_q == ST_WAIT));
  // R8: truncated field is flagged
  p_trunc_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_trunc |=> err_o);
  // R1: a skipped row stays silent
  p_skip_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SKIP) |=> !pair_vld_o);
endmodule

// File: tb/test_emb_row_parser.sv
module test_emb_row_parser;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_vld_i = 1'b0;
  logic line_vld_i = 1'b0;
  logic [11:0] pix_data_i = '0;
  logic pair_vld_o, err_o;
  logic [15:0] pair_addr_o, pair_val_o;

  int n_cmp = 0;
  int n_bad = 0;
  int n_unexp = 0;
  bit mon_on = 1'b0;

  bit          q_err[$];
  logic [31:0] q_dat[$];
  string       q_req[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  emb_row_parser i_emb_row_parser (
    .clk(clk), .rst_n(rst_n), .pix_vld_i(pix_vld_i), .line_vld_i(line_vld_i),
    .pix_data_i(pix_data_i), .pair_vld_o(pair_vld_o), .pair_addr_o(pair_addr_o),
    .pair_val_o(pair_val_o), .err_o(err_o)
  );

  task automatic exp_pair(input logic [15:0] a, input logic [15:0] v, input string req);
    q_err.push_back(1'b0); q_dat.push_back({a, v}); q_req.push_back(req);
  endtask

  task automatic exp_err(input string req);
    q_err.push_back(1'b1); q_dat.push_back('0); q_req.push_back(req);
  endtask

  // monitor: pops expected items as outputs appear
  always @(negedge clk) begin
    if (mon_on && (pair_vld_o || err_o)) begin
      if (q_err.size() == 0) begin
        n_unexp++; n_cmp++; n_bad++;
        $display("FAIL unexpected output: pair=%0b addr=%h val=%h err=%0b expected none",
                 pair_vld_o, pair_addr_o, pair_val_o, err_o);
      end else begin
        automatic bit e = q_err.pop_front();
        automatic logic [31:0] d = q_dat.pop_front();
        automatic string r = q_req.pop_front();
        n_cmp++;
        if (e) begin
          if (!(err_o && !pair_vld_o)) begin
            n_bad++;
            $display("FAIL %s: err=%0b pair=%0b expected err=1 pair=0", r, err_o, pair_vld_o);
          end
        end else if (!(pair_vld_o && !err_o && {pair_addr_o, pair_val_o} == d)) begin
          n_bad++;
          $display("FAIL %s: pair=%0b err=%0b addr/val=%h expected %h",
                   r, pair_vld_o, err_o, {pair_addr_o, pair_val_o}, d);
        end
      end
    end
  end

  task automatic put(input logic [11:0] w);
    pix_data_i = w; pix_vld_i = 1'b1;
    @(negedge clk);
    pix_vld_i = 1'b0; pix_data_i = 12'hFFF;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic put_byte(input logic [7:0] b);
    put({b, 4'h0});
  endtask

  task automatic row_begin();
    line_vld_i = 1'b1;
    @(negedge clk);
  endtask

  task automatic row_end();
    line_vld_i = 1'b0;
    idle(3);
  endtask

  task automatic send_header(input logic [15:0] a);
    put(12'h0A0);
    put_byte(8'hAA); put_byte(a[15:8]); put_byte(8'hA5); put_byte(a[7:0]);
  endtask

  task automatic send_value(input logic [15:0] v);
    put_byte(8'h5A); put_byte(v[15:8]); put_byte(8'h5A); put_byte(v[7:0]);
  endtask

  task automatic check_drained(input string req);
    idle(2);
    n_cmp++;
    if (q_err.size() != 0 || n_unexp != 0) begin
      n_bad++;
      $display("FAIL %s: pending=%0d unexpected=%0d expected 0/0", req, q_err.size(), n_unexp);
    end
    n_unexp = 0;
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] vals[3];
    pix_data_i = 12'hFFF;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    n_cmp++;
    if (pair_vld_o !== 1'b0 || err_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R9 reset: pair=%0b err=%0b expected 0/0", pair_vld_o, err_o);
    end
    mon_on = 1'b1;

    // R2 R3 R4 R5: basic row, explicit words for 0x1234
    exp_pair(16'h3000, 16'h1234, "R4 join 0x120/0x340");
    exp_pair(16'h3002, 16'hBEEF, "R5 step +2");
    exp_pair(16'h3004, 16'h0001, "R5 step +4");
    row_begin();
    send_header(16'h3000);
    put(12'h5A0); put(12'h120); put(12'h5A0); put(12'h340);
    send_value(16'hBEEF);
    send_value(16'h0001);
    row_end();
    check_drained("R3 R4 basic row");

    // R1: rows not starting with the tag produce nothing
    row_begin();
    put(12'h0A8);
    put_byte(8'hAA); put_byte(8'h30); put_byte(8'hA5); put_byte(8'h00);
    send_value(16'h1111);
    row_end();
    row_begin();
    put(12'h000); put(12'h0A0);
    put_byte(8'hAA); put_byte(8'h30); put_byte(8'hA5); put_byte(8'h00);
    send_value(16'h2222);
    row_end();
    check_drained("R1 non-tag rows silent");

    // R6: bad header marker, rest ignored
    exp_err("R6 header marker mismatch");
    row_begin();
    put(12'h0A0); put_byte(8'hAA); put_byte(8'h30); put_byte(8'hA4);
    put_byte(8'h00); send_value(16'h3333); send_value(16'h4444);
    row_end();
    check_drained("R6 rest of row ignored");

    // R6: bad value marker after one good value
    exp_pair(16'h0100, 16'hCAFE, "R6 good value before fault");
    exp_err("R6 value marker mismatch");
    row_begin();
    send_header(16'h0100); send_value(16'hCAFE);
    put_byte(8'h5B); put_byte(8'h12); put_byte(8'h5A); put_byte(8'h34);
    row_end();
    check_drained("R6 after value fault");

    // R7: non-zero pad on a data byte, then on a marker
    exp_err("R7 pad bits on data byte");
    row_begin();
    send_header(16'h1200);
    put(12'h5A0); put(12'h123); put(12'h5A0); put(12'h340);
    row_end();
    exp_pair(16'h2000, 16'h00FF, "R7 good value before pad fault");
    exp_err("R7 pad bits on marker");
    row_begin();
    send_header(16'h2000); send_value(16'h00FF);
    put(12'h5A8); put(12'h120); put(12'h5A0); put(12'h340);
    row_end();
    check_drained("R7 pad faults");

    // R8: truncation mid value and mid header; clean end after header
    exp_pair(16'h31D0, 16'hA5A5, "R8 value before truncation");
    exp_err("R8 truncated mid value");
    row_begin();
    send_header(16'h31D0); send_value(16'hA5A5);
    put_byte(8'h5A); put_byte(8'h12);
    row_end();
    exp_err("R8 truncated mid header");
    row_begin();
    put(12'h0A0); put_byte(8'hAA); put_byte(8'h12);
    row_end();
    row_begin();
    send_header(16'h4000);
    row_end();
    check_drained("R8 end handling");

    // R10: junk while line-valid low, gaps with pix_vld low; R5 wrap
    line_vld_i = 1'b0;
    put(12'h0A0); put_byte(8'hAA); put_byte(8'h00); put_byte(8'hA5);
    put_byte(8'h00); send_value(16'h7777);
    check_drained("R10 words with line low ignored");
    vals[0] = 16'h0102; vals[1] = 16'h0304; vals[2] = 16'h0506;
    exp_pair(16'hFFFC, vals[0], "R10 gapped value 0");
    exp_pair(16'hFFFE, vals[1], "R5 gapped value 1");
    exp_pair(16'h0000, vals[2], "R5 address wrap");
    row_begin();
    put(12'h0A0); idle(2);
    put_byte(8'hAA); idle(1); put_byte(8'hFF); idle(3);
    put_byte(8'hA5); put_byte(8'hFC);
    foreach (vals[k]) begin
      put_byte(8'h5A); idle(1); put_byte(vals[k][15:8]); idle(2);
      put_byte(8'h5A); put_byte(vals[k][7:0]); idle(1);
    end
    row_end();
    check_drained("R10 R5 gaps and wrap");

    idle(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule